// File: doc/BRIEF.md
# Register-Reference Operation Unit

This block is a purely combinational execution unit for the register-class instructions of a small accumulator machine. It takes the present accumulator, the single carry/extend bit, and the 12-bit operation field of the instruction. It returns the next accumulator value, the next carry value, a skip request and a halt request.

The operation field is a one-hot mask. Each bit position selects one operation, so no opcode decoding takes place. The surrounding sequencer owns memory, the program counter and timing. It writes back the accumulator and carry, advances the program counter by one extra word when skip is raised, and stops when halt is raised.

A field that does not have exactly one bit set is flagged as illegal. In that case the unit leaves the machine state untouched.

Top module: `rro_unit`

## Requirements
- R1: With field bit 11 (value 0x800) alone set, the next accumulator is all zeros and the carry is passed through unchanged.
- R2: With field bit 10 (0x400) alone set, the next carry is 0 and the accumulator is passed through unchanged.
- R3: Bit 9 (0x200) alone gives the bitwise inverse of the accumulator and keeps the carry. Bit 8 (0x100) alone inverts the carry and keeps the accumulator.
- R4: Bit 7 (0x080) alone rotates right through the carry. The carry enters the accumulator MSB, and the accumulator LSB becomes the next carry.
- R5: Bit 6 (0x040) alone rotates left through the carry. The carry enters the accumulator LSB, and the accumulator MSB becomes the next carry.
- R6: Bit 5 (0x020) alone adds one to the accumulator modulo 2^16, so 0xFFFF wraps to 0x0000, and the carry is left unchanged.
- R7: Bit 4 (0x010) alone raises skip when accumulator bit 15 is 0, which includes a zero accumulator. Bit 3 (0x008) alone raises skip when bit 15 is 1.
- R8: Bit 2 (0x004) alone raises skip when the accumulator is zero. Bit 1 (0x002) alone raises skip when the carry is 0.
- R9: Bit 0 (0x001) alone raises halt. The accumulator and carry are unchanged and skip stays low.
- R10: A field with zero bits or with two or more bits set raises illegal. It leaves the accumulator and carry unchanged and keeps skip and halt low. Every single-bit field keeps illegal low.
- R11: The skip tests (bits 4..1) never change the accumulator or carry. The operations on bits 11..5 never raise skip or halt. Skip and halt are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| acc_in | input | 16 | Present accumulator value |
| carry_in | input | 1 | Present carry/extend bit |
| op_field | input | 12 | One-hot operation mask from the instruction |
| acc_out | output | 16 | Next accumulator value |
| carry_out | output | 1 | Next carry/extend bit |
| skip_req | output | 1 | Request to skip the next instruction |
| halt_req | output | 1 | Request to stop the machine |
| illegal | output | 1 | Field does not have exactly one bit set |

## Verification
The bench targets the rotate boundaries, with the carry and the end bits set to opposite values. A unit that wrapped inside the accumulator, or that rotated in the wrong direction, would return the wrong MSB/LSB or the wrong carry. It increments 0xFFFF to catch a unit that lets the wrap leak into the carry. It tests the sign skip with a zero accumulator, which would catch a strict-positive test. It also drives empty fields, two-bit fields and full fields, where a priority decoder would quietly execute one of the requested operations instead of flagging illegal and holding state.

// File: rtl/rro_pkg.sv
package rro_pkg;

    localparam int FIELD_W = 12;

    // Bit positions inside the operation mask (the caller relies on these)
    localparam int BIT_CLA = 11;
    localparam int BIT_CLE = 10;
    localparam int BIT_CMA = 9;
    localparam int BIT_CME = 8;
    localparam int BIT_CIR = 7;
    localparam int BIT_CIL = 6;
    localparam int BIT_INC = 5;
    localparam int BIT_SPA = 4;
    localparam int BIT_SNA = 3;
    localparam int BIT_SZA = 2;
    localparam int BIT_SZE = 1;
    localparam int BIT_HLT = 0;

    typedef enum logic [3:0] {
        OP_NONE,
        OP_ZERO_AC,
        OP_ZERO_E,
        OP_INV_AC,
        OP_INV_E,
        OP_ROT_R,
        OP_ROT_L,
        OP_BUMP,
        OP_T_POS,
        OP_T_NEG,
        OP_T_ZAC,
        OP_T_ZE,
        OP_STOP
    } rro_op_e;

    typedef struct packed {
        logic skip;
        logic halt;
    } rro_ctl_t;

    function automatic logic single_bit(input logic [FIELD_W-1:0] f);
        return (f != '0) && ((f & (f - FIELD_W'(1))) == '0);
    endfunction

    function automatic rro_op_e op_of_bit(input int idx);
        case (idx)
            BIT_CLA: return OP_ZERO_AC;
            BIT_CLE: return OP_ZERO_E;
            BIT_CMA: return OP_INV_AC;
            BIT_CME: return OP_INV_E;
            BIT_CIR: return OP_ROT_R;
            BIT_CIL: return OP_ROT_L;
            BIT_INC: return OP_BUMP;
            BIT_SPA: return OP_T_POS;
            BIT_SNA: return OP_T_NEG;
            BIT_SZA: return OP_T_ZAC;
            BIT_SZE: return OP_T_ZE;
            BIT_HLT: return OP_STOP;
            default: return OP_NONE;
        endcase
    endfunction

    function automatic logic is_test_op(input rro_op_e op);
        return (op == OP_T_POS) || (op == OP_T_NEG) || (op == OP_T_ZAC) || (op == OP_T_ZE);
    endfunction

endpackage

// File: rtl/rro_decode.sv
module rro_decode
    import rro_pkg::*;
(
    input  logic [FIELD_W-1:0] field,
    output rro_op_e            op,
    output logic               bad
);
    logic             legal;
    logic [FIELD_W-1:0] hit;

    assign legal = single_bit(field);
    assign bad   = ~legal;

    generate
        for (genvar i = 0; i < FIELD_W; i++) begin : g_hit
            assign hit[i] = field[i] & legal;
        end
    endgenerate

    always_comb begin
        op = OP_NONE;
        for (int i = 0; i < FIELD_W; i++) begin
            if (hit[i]) op = op_of_bit(i);
        end
    end

    always_comb begin
        AST_ILLEGAL_COUNT: assert (bad == ($countones(field) != 1)); // R10
        if (bad) begin
            AST_ILLEGAL_NO_OP: assert (op == OP_NONE); // R10
        end else begin
            AST_LEGAL_HAS_OP: assert (op != OP_NONE); // R10
        end
    end
endmodule

// File: rtl/rro_datapath.sv
module rro_datapath
    import rro_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  rro_op_e           op,
    input  logic [DATA_W-1:0] acc,
    input  logic              cin,
    output logic [DATA_W-1:0] acc_nx,
    output logic              cout
);
    localparam int MSB = DATA_W - 1;
    localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

    always_comb begin
        acc_nx = acc;
        cout   = cin;
        unique case (op)
            OP_ZERO_AC: acc_nx = '0;
            OP_ZERO_E:  cout   = 1'b0;
            OP_INV_AC:  acc_nx = ~acc;
            OP_INV_E:   cout   = ~cin;
            OP_ROT_R: begin
                acc_nx = {cin, acc[MSB:1]};
                cout   = acc[0];
            end
            OP_ROT_L: begin
                acc_nx = {acc[MSB-1:0], cin};
                cout   = acc[MSB];
            end
            OP_BUMP:    acc_nx = acc + ONE;
            default: ;
        endcase
    end

    always_comb begin
        if (op == OP_BUMP) begin
            AST_BUMP_STEP: assert ((acc_nx - acc) == ONE); // R6
            AST_BUMP_KEEPS_E: assert (cout == cin); // R6
        end
        if (op == OP_ROT_R || op == OP_ROT_L) begin
            AST_ROT_CONSERVES: assert ($countones({cout, acc_nx}) == $countones({cin, acc})); // R4
        end
        if (op == OP_NONE || op == OP_STOP || is_test_op(op)) begin
            AST_STATE_HELD: assert (acc_nx == acc && cout == cin); // R11
        end
    end
endmodule

// File: rtl/rro_cond.sv
module rro_cond
    import rro_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  rro_op_e           op,
    input  logic [DATA_W-1:0] acc,
    input  logic              cin,
    output rro_ctl_t          ctl
);
    localparam int MSB = DATA_W - 1;

    logic sign;
    logic ac_zero;

    assign sign    = acc[MSB];
    assign ac_zero = (acc == '0);

    always_comb begin
        ctl = '0;
        unique case (op)
            OP_T_POS: ctl.skip = ~sign;
            OP_T_NEG: ctl.skip = sign;
            OP_T_ZAC: ctl.skip = ac_zero;
            OP_T_ZE:  ctl.skip = ~cin;
            OP_STOP:  ctl.halt = 1'b1;
            default: ;
        endcase
    end

    always_comb begin
        AST_SKIP_HALT_EXCL: assert ($onehot0({ctl.skip, ctl.halt})); // R11
        if (ctl.skip) begin
            AST_SKIP_ONLY_TESTS: assert (is_test_op(op)); // R11
        end
        if (ctl.halt) begin
            AST_HALT_SOURCE: assert (op == OP_STOP); // R9
        end
        if (op == OP_T_ZAC && ctl.skip) begin
            AST_ZERO_SKIP_NOT_NEG: assert (!sign); // R8
        end
    end
endmodule

// File: rtl/rro_unit.sv
module rro_unit
    import rro_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0]  acc_in,
    input  logic               carry_in,
    input  logic [FIELD_W-1:0] op_field,
    output logic [DATA_W-1:0]  acc_out,
    output logic               carry_out,
    output logic               skip_req,
    output logic               halt_req,
    output logic               illegal
);
    rro_op_e  op;
    rro_ctl_t ctl;

    rro_decode u_decode (
        .field (op_field),
        .op    (op),
        .bad   (illegal)
    );

    rro_datapath #(.DATA_W(DATA_W)) u_datapath (
        .op     (op),
        .acc    (acc_in),
        .cin    (carry_in),
        .acc_nx (acc_out),
        .cout   (carry_out)
    );

    rro_cond #(.DATA_W(DATA_W)) u_cond (
        .op  (op),
        .acc (acc_in),
        .cin (carry_in),
        .ctl (ctl)
    );

    assign skip_req = ctl.skip;
    assign halt_req = ctl.halt;
endmodule

// File: tb/rro_unit_tb.sv
module rro_unit_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 5000;

    typedef struct {
        logic [15:0] acc;
        logic        e;
        logic [11:0] f;
        logic [15:0] x_acc;
        logic        x_e;
        logic        x_skip;
        logic        x_halt;
        logic        x_ill;
        string       tag;
    } item_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] acc_in = '0;
    logic        carry_in = 1'b0;
    logic [11:0] op_field = '0;
    logic [15:0] acc_out;
    logic        carry_out, skip_req, halt_req, illegal;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    item_t sb[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    rro_unit dut_i (
        .acc_in    (acc_in),
        .carry_in  (carry_in),
        .op_field  (op_field),
        .acc_out   (acc_out),
        .carry_out (carry_out),
        .skip_req  (skip_req),
        .halt_req  (halt_req),
        .illegal   (illegal)
    );

    // Reference model written from the requirements
    function automatic item_t model(logic [15:0] a, logic e, logic [11:0] f, string tag);
        item_t it;
        it.acc = a; it.e = e; it.f = f; it.tag = tag;
        it.x_acc = a; it.x_e = e; it.x_skip = 0; it.x_halt = 0; it.x_ill = 0;
        case (f)
            12'h800: it.x_acc = 16'h0000;
            12'h400: it.x_e = 1'b0;
            12'h200: it.x_acc = a ^ 16'hFFFF;
            12'h100: it.x_e = !e;
            12'h080: begin it.x_acc = {e, a[15:1]}; it.x_e = a[0]; end
            12'h040: begin it.x_acc = {a[14:0], e}; it.x_e = a[15]; end
            12'h020: it.x_acc = 16'(a + 16'd1);
            12'h010: it.x_skip = (a[15] == 1'b0);
            12'h008: it.x_skip = (a[15] == 1'b1);
            12'h004: it.x_skip = (a == 16'h0000);
            12'h002: it.x_skip = (e == 1'b0);
            12'h001: it.x_halt = 1'b1;
            default: it.x_ill = 1'b1;
        endcase
        return it;
    endfunction

    task automatic drive(logic [15:0] a, logic e, logic [11:0] f, string tag);
        @(posedge clk);
        #1;
        acc_in = a; carry_in = e; op_field = f;
        sb.push_back(model(a, e, f, tag));
    endtask

    task automatic cmp(string tag, string what, logic [15:0] act, logic [15:0] exp, item_t it);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s field=%h acc=%h e=%b actual=%h expected=%h",
                     tag, what, it.f, it.acc, it.e, act, exp);
        end
    endtask

    // Monitor: pop one expected item per cycle, away from the driving edge
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            item_t it;
            it = sb.pop_front();
            cmp(it.tag, "acc",     acc_out,          it.x_acc,          it);
            cmp(it.tag, "carry",   16'(carry_out),   16'(it.x_e),       it);
            cmp(it.tag, "skip",    16'(skip_req),    16'(it.x_skip),    it);
            cmp(it.tag, "halt",    16'(halt_req),    16'(it.x_halt),    it);
            cmp(it.tag, "illegal", 16'(illegal),     16'(it.x_ill),     it);
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        rst = 1'b0;
        // Initial state after reset: empty field, must be flagged and hold state (R10)
        drive(16'h0000, 1'b0, 12'h000, "R10");
        // R1 clear accumulator
        drive(16'hBEEF, 1'b1, 12'h800, "R1");
        drive(16'h0001, 1'b0, 12'h800, "R1");
        // R2 clear carry
        drive(16'h1234, 1'b1, 12'h400, "R2");
        drive(16'h1234, 1'b0, 12'h400, "R2");
        // R3 complements
        drive(16'h00FF, 1'b1, 12'h200, "R3");
        drive(16'hA5A5, 1'b0, 12'h100, "R3");
        drive(16'hA5A5, 1'b1, 12'h100, "R3");
        // R4 rotate right through carry
        drive(16'h0001, 1'b0, 12'h080, "R4");
        drive(16'h8000, 1'b1, 12'h080, "R4");
        drive(16'hF0F0, 1'b1, 12'h080, "R4");
        // R5 rotate left through carry
        drive(16'h8000, 1'b0, 12'h040, "R5");
        drive(16'h0001, 1'b1, 12'h040, "R5");
        drive(16'h7FFF, 1'b0, 12'h040, "R5");
        // R6 increment, wrap without touching carry
        drive(16'hFFFF, 1'b0, 12'h020, "R6");
        drive(16'h00FF, 1'b1, 12'h020, "R6");
        // R7 sign tests, zero counts as positive
        drive(16'h0000, 1'b0, 12'h010, "R7");
        drive(16'h8000, 1'b0, 12'h010, "R7");
        drive(16'h7FFF, 1'b1, 12'h010, "R7");
        drive(16'h8000, 1'b0, 12'h008, "R7");
        drive(16'h0000, 1'b1, 12'h008, "R7");
        // R8 zero tests
        drive(16'h0000, 1'b1, 12'h004, "R8");
        drive(16'h0001, 1'b0, 12'h004, "R8");
        drive(16'h8000, 1'b0, 12'h004, "R8");
        drive(16'h5555, 1'b0, 12'h002, "R8");
        drive(16'h5555, 1'b1, 12'h002, "R8");
        // R9 halt
        drive(16'h4321, 1'b1, 12'h001, "R9");
        // R10 illegal fields
        drive(16'hCAFE, 1'b1, 12'h003, "R10");
        drive(16'hCAFE, 1'b0, 12'hFFF, "R10");
        drive(16'h0000, 1'b1, 12'h840, "R10");
        drive(16'h0000, 1'b0, 12'h014, "R10");
        // R11 test ops do not alter state, modifiers do not skip
        drive(16'h0000, 1'b0, 12'h800, "R11");
        drive(16'hFFFF, 1'b1, 12'h004, "R11");
        repeat (3) @(posedge clk);
        done = 1'b1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < WATCHDOG) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired after %0d cycles (expected completion)", cyc);
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule